// File: doc/BRIEF.md
# Domain-Tagged IOTLB with Selective Invalidation

This block is a small, fully associative translation cache for an I/O memory management unit. Each resident slot stores a domain identifier, a requester (source) identifier, a PASID, the page-aligned input frame, a page-size frame mask, the translated output frame, two permission bits and a 3-bit translation-type tag. The tag records which walk produced the mapping: first-stage or second-stage.

Three ports share the slot array. A lookup port returns, one cycle later, a hit flag, the translated frame and the permissions. A fill port installs the result of a page walk, which runs outside this block. An invalidation port accepts global, domain-wide and page-selective-within-domain requests.

The page-selective request treats the two tags differently. First-stage slots of the named domain are dropped whatever their address. Second-stage slots are dropped only when their page overlaps the requested range. The overlap is tested two ways: once against the request's range mask, and once against the slot's own page mask. A small invalidation range that falls inside a large cached page still removes that page.

Top module: `iotlb_dom_cache`

## Requirements
- R1: A lookup presented in cycle t produces `lk_resp_valid` in cycle t+1. `lk_hit` is 1 only when some valid slot matches all of the following: source identifier, PASID, and the slot frame equal to the lookup frame (`lk_addr[47:12]`) ANDed with the slot's page frame mask. When several slots match, the lowest-numbered slot answers. With no lookup, `lk_resp_valid` and `lk_hit` are 0.
- R2: `fill_level` sets the page size. The value 2 gives a 2 MiB page (9 low frame bits cleared). The value 3 gives a 1 GiB page (18 low frame bits cleared). Any other value gives a 4 KiB page. On a hit, `lk_frame` takes the slot's translated frame in the bits the page mask keeps, and takes the lookup frame in the bits it clears. `lk_perm` is the stored permission value.
- R3: A fill is tagged first-stage (001b) when `fill_first_en` and `fill_scalable` are both 1, and second-stage (010b) otherwise. A fill with `fill_passthru` set installs nothing.
- R4: `inv_kind` = 00 (global) clears every slot.
- R5: `inv_kind` = 01 (domain) clears every slot whose domain equals `inv_dom`, whatever its tag, and keeps all other slots.
- R6: `inv_kind` = 10 (page-selective) never clears a slot whose domain differs from `inv_dom`.
- R7: For a page-selective request, a slot of the same domain tagged first-stage is cleared regardless of `inv_addr` and `inv_order`.
- R8: For a page-selective request, a same-domain second-stage slot is cleared when either of two tests holds. Let F be the request frame (`inv_addr[47:12]`) and M be the all-ones frame mask shifted left by `inv_order`. The first test is (slot frame AND M) == (F AND M). The second test is slot frame == (F AND slot page mask). Otherwise the slot is kept.
- R9: `inv_kind` = 11 has no effect.
- R10: A fill goes to the lowest-numbered free slot. When no slot is free, it goes to the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R11: An invalidation and a fill in the same cycle apply the invalidation first. A slot the invalidation frees is available to that fill, and the filled slot is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | 16 | Lookup source identifier |
| lk_pasid | input | 20 | Lookup PASID |
| lk_addr | input | 48 | Lookup input address |
| lk_resp_valid | output | 1 | Registered lookup response valid |
| lk_hit | output | 1 | Registered hit flag |
| lk_frame | output | 36 | Translated output frame |
| lk_perm | output | 2 | Permission bits of the hitting slot |
| fill_valid | input | 1 | Install request |
| fill_passthru | input | 1 | Mapping is pass-through; do not install |
| fill_first_en | input | 1 | First-stage translation enabled |
| fill_scalable | input | 1 | Scalable mode enabled |
| fill_dom | input | 16 | Domain of the new mapping |
| fill_sid | input | 16 | Source identifier of the new mapping |
| fill_pasid | input | 20 | PASID of the new mapping |
| fill_addr | input | 48 | Input address of the new mapping |
| fill_level | input | 2 | Page-table level of the leaf |
| fill_hpfn | input | 36 | Translated frame |
| fill_perm | input | 2 | Permission bits |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 00 global, 01 domain, 10 page-selective, 11 no effect |
| inv_dom | input | 16 | Domain for domain and page-selective requests |
| inv_addr | input | 48 | Address for page-selective requests |
| inv_order | input | 6 | Range order: number of low frame bits ignored |

## Verification
The hardest case is the second overlap test. In that case a narrow invalidation range misses a cached large page under the range mask, yet still falls inside it under the slot's own mask. To reach it, the stimulus fills a 1 GiB second-stage page, issues an order-0 request at an address inside that page but off its base, and then looks the page up to see it gone. A same-domain first-stage slot sits beside it. A request at an unrelated address must remove only that first-stage slot, which is the only way the type tag is visible at the ports. Round-robin replacement is reached by filling past capacity after a global clear. A same-cycle invalidation plus fill is issued on a full cache, so the fill can land only in a slot the invalidation freed.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ADDR_W     = 48;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = ADDR_W - PAGE_SHIFT;
  localparam int DOM_W      = 16;
  localparam int SID_W      = 16;
  localparam int PASID_W    = 20;
  localparam int PERM_W     = 2;
  localparam int ORDER_W    = 6;
  localparam int LEVEL_W    = 2;
  localparam int TAG_W      = 3;
  localparam int LEVEL_BITS = 9;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [TAG_W-1:0] {
    XT_FIRST  = 3'b001,
    XT_SECOND = 3'b010,
    XT_NESTED = 3'b011,
    XT_PASS   = 3'b100
  } xlat_tag_e;

  typedef enum logic [1:0] {
    INV_GLOBAL = 2'b00,
    INV_DOMAIN = 2'b01,
    INV_PAGE   = 2'b10,
    INV_RSVD   = 2'b11
  } inv_kind_e;

  typedef struct packed {
    logic [DOM_W-1:0]   dom;
    logic [SID_W-1:0]   sid;
    logic [PASID_W-1:0] pasid;
    frame_t             gfn;
    frame_t             pfm;
    frame_t             hpfn;
    logic [PERM_W-1:0]  perm;
    xlat_tag_e          tag;
  } slot_t;

  // Frame mask of a leaf page: larger levels clear more low frame bits.
  function automatic frame_t level_frame_mask(input logic [LEVEL_W-1:0] level);
    frame_t m;
    m = '1;
    case (level)
      2'd2:    m = m << LEVEL_BITS;
      2'd3:    m = m << (2 * LEVEL_BITS);
      default: m = '1;
    endcase
    return m;
  endfunction

  // Range mask of an invalidation: all ones with 'order' low bits cleared.
  function automatic frame_t order_frame_mask(input logic [ORDER_W-1:0] order);
    frame_t m;
    m = '1;
    return m << order;
  endfunction

  function automatic frame_t addr_frame(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  // Overlap test for second-stage slots, checked from both sides.
  function automatic logic range_overlap(input frame_t slot_gfn, input frame_t slot_pfm,
                                         input frame_t req_frame, input frame_t range_mask);
    return ((slot_gfn & range_mask) == (req_frame & range_mask)) ||
           (slot_gfn == (req_frame & slot_pfm));
  endfunction

  function automatic frame_t compose_frame(input frame_t hpfn, input frame_t pfm,
                                           input frame_t req_frame);
    return (hpfn & pfm) | (req_frame & ~pfm);
  endfunction
endpackage

// File: rtl/iotlb_lookup.sv
module iotlb_lookup
  import iotlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  slot_t                slots [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] slot_valid,
  input  logic                 req_valid,
  input  logic [SID_W-1:0]     req_sid,
  input  logic [PASID_W-1:0]   req_pasid,
  input  frame_t               req_frame,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output frame_t               resp_frame,
  output logic [PERM_W-1:0]    resp_perm
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] match;
  logic [IDX_W-1:0]     sel;
  logic                 any_match;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign match[g] = slot_valid[g] &&
                      (slots[g].sid == req_sid) &&
                      (slots[g].pasid == req_pasid) &&
                      ((req_frame & slots[g].pfm) == slots[g].gfn);
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign any_match = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_frame <= '0;
      resp_perm  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_hit   <= req_valid && any_match;
      if (req_valid && any_match) begin
        resp_frame <= compose_frame(slots[sel].hpfn, slots[sel].pfm, req_frame);
        resp_perm  <= slots[sel].perm;
      end else begin
        resp_frame <= '0;
        resp_perm  <= '0;
      end
    end
  end
endmodule

// File: rtl/iotlb_inv_match.sv
module iotlb_inv_match
  import iotlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  slot_t                slots [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] slot_valid,
  input  logic                 inv_valid,
  input  inv_kind_e            inv_kind,
  input  logic [DOM_W-1:0]     inv_dom,
  input  frame_t               inv_frame,
  input  logic [ORDER_W-1:0]   inv_order,
  output logic [NUM_SLOTS-1:0] kill
);
  frame_t range_mask;
  assign range_mask = order_frame_mask(inv_order);

  function automatic logic slot_killed(input slot_t s, input inv_kind_e k,
                                       input logic [DOM_W-1:0] d, input frame_t f,
                                       input frame_t rm);
    logic same_dom;
    same_dom = (s.dom == d);
    case (k)
      INV_GLOBAL: return 1'b1;
      INV_DOMAIN: return same_dom;
      INV_PAGE: begin
        if (!same_dom) return 1'b0;
        if (s.tag == XT_FIRST || s.tag == XT_NESTED) return 1'b1;
        return range_overlap(s.gfn, s.pfm, f, rm);
      end
      default:    return 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_kill
    assign kill[g] = inv_valid && slot_valid[g] &&
                     slot_killed(slots[g], inv_kind, inv_dom, inv_frame, range_mask);
  end
endmodule

// File: rtl/iotlb_alloc.sv
module iotlb_alloc #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] live,
  input  logic                 take,
  output logic [IDX_W-1:0]     victim,
  output logic                 replace_evt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim      = any_free ? free_idx : rr_ptr;
  assign replace_evt = take && !any_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (replace_evt) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/iotlb_dom_cache.sv
module iotlb_dom_cache
  import iotlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [15:0]        lk_sid,
  input  logic [19:0]        lk_pasid,
  input  logic [47:0]        lk_addr,
  output logic               lk_resp_valid,
  output logic               lk_hit,
  output logic [35:0]        lk_frame,
  output logic [1:0]         lk_perm,
  input  logic               fill_valid,
  input  logic               fill_passthru,
  input  logic               fill_first_en,
  input  logic               fill_scalable,
  input  logic [15:0]        fill_dom,
  input  logic [15:0]        fill_sid,
  input  logic [19:0]        fill_pasid,
  input  logic [47:0]        fill_addr,
  input  logic [1:0]         fill_level,
  input  logic [35:0]        fill_hpfn,
  input  logic [1:0]         fill_perm,
  input  logic               inv_valid,
  input  logic [1:0]         inv_kind,
  input  logic [15:0]        inv_dom,
  input  logic [47:0]        inv_addr,
  input  logic [5:0]         inv_order
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  slot_t                      slots [NUM_SLOTS];
  slot_t                      fill_slot;
  logic [NUM_SLOTS-1:0]       slot_valid;
  logic [NUM_SLOTS-1:0]       inv_kill;
  logic [NUM_SLOTS-1:0]       live_after_inv;
  logic [NUM_SLOTS-1:0]       fill_onehot;
  logic [IDX_W-1:0]           victim;
  logic                       fill_take;
  logic                       replace_evt;
  logic [NUM_SLOTS*DOM_W-1:0] slot_dom_flat;
  logic [NUM_SLOTS*TAG_W-1:0] slot_tag_flat;

  assign fill_take      = fill_valid && !fill_passthru;
  assign live_after_inv = slot_valid & ~inv_kill;

  always_comb begin
    fill_slot.pfm   = level_frame_mask(fill_level);
    fill_slot.gfn   = addr_frame(fill_addr) & fill_slot.pfm;
    fill_slot.hpfn  = fill_hpfn & fill_slot.pfm;
    fill_slot.dom   = fill_dom;
    fill_slot.sid   = fill_sid;
    fill_slot.pasid = fill_pasid;
    fill_slot.perm  = fill_perm;
    fill_slot.tag   = (fill_first_en && fill_scalable) ? XT_FIRST : XT_SECOND;
  end

  iotlb_inv_match #(.NUM_SLOTS(NUM_SLOTS)) u_inv (
    .slots      (slots),
    .slot_valid (slot_valid),
    .inv_valid  (inv_valid),
    .inv_kind   (inv_kind_e'(inv_kind)),
    .inv_dom    (inv_dom),
    .inv_frame  (addr_frame(inv_addr)),
    .inv_order  (inv_order),
    .kill       (inv_kill)
  );

  iotlb_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .clk         (clk),
    .rst_n       (rst_n),
    .live        (live_after_inv),
    .take        (fill_take),
    .victim      (victim),
    .replace_evt (replace_evt)
  );

  iotlb_lookup #(.NUM_SLOTS(NUM_SLOTS)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .slots      (slots),
    .slot_valid (slot_valid),
    .req_valid  (lk_valid),
    .req_sid    (lk_sid),
    .req_pasid  (lk_pasid),
    .req_frame  (addr_frame(lk_addr)),
    .resp_valid (lk_resp_valid),
    .resp_hit   (lk_hit),
    .resp_frame (lk_frame),
    .resp_perm  (lk_perm)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign fill_onehot[g] = fill_take && (victim == IDX_W'(g));
    assign slot_dom_flat[g*DOM_W +: DOM_W] = slots[g].dom;
    assign slot_tag_flat[g*TAG_W +: TAG_W] = slots[g].tag;

    always_ff @(posedge clk) begin
      if (fill_onehot[g]) slots[g] <= fill_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_valid <= '0;
    else        slot_valid <= live_after_inv | fill_onehot;
  end
endmodule

// File: rtl/iotlb_dom_cache_chk.sv
module iotlb_dom_cache_chk
  import iotlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic                       lk_resp_valid,
  input logic                       lk_hit,
  input logic                       fill_valid,
  input logic                       fill_passthru,
  input logic                       inv_valid,
  input logic [1:0]                 inv_kind,
  input logic [DOM_W-1:0]           inv_dom,
  input logic [NUM_SLOTS-1:0]       slot_valid,
  input logic [NUM_SLOTS-1:0]       inv_kill,
  input logic [NUM_SLOTS*DOM_W-1:0] slot_dom_flat,
  input logic [NUM_SLOTS*TAG_W-1:0] slot_tag_flat
);
  logic take;
  assign take = fill_valid && !fill_passthru;

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_resp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_resp_valid && !lk_hit));
  assert_global_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'b00 && !take) |=> (slot_valid == '0));
  assert_rsvd_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'b11) |-> (inv_kill == '0));
  assert_fill_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !inv_valid && $countones(slot_valid) < NUM_SLOTS) |=>
    ($countones(slot_valid) == $past($countones(slot_valid)) + 1));
  assert_full_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !inv_valid && (&slot_valid)) |=> (&slot_valid));
  assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (slot_valid != '0));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    logic [DOM_W-1:0] d;
    logic [TAG_W-1:0] t;
    assign d = slot_dom_flat[g*DOM_W +: DOM_W];
    assign t = slot_tag_flat[g*TAG_W +: TAG_W];

    assert_keep_foreign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'b10 && slot_valid[g] && d != inv_dom) |-> !inv_kill[g]);
    assert_first_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'b10 && slot_valid[g] && d == inv_dom && t == 3'b001)
      |-> inv_kill[g]);
    assert_domain_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'b01 && slot_valid[g]) |-> (inv_kill[g] == (d == inv_dom)));
  end
endmodule

bind iotlb_dom_cache iotlb_dom_cache_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_resp_valid (lk_resp_valid),
  .lk_hit        (lk_hit),
  .fill_valid    (fill_valid),
  .fill_passthru (fill_passthru),
  .inv_valid     (inv_valid),
  .inv_kind      (inv_kind),
  .inv_dom       (inv_dom),
  .slot_valid    (slot_valid),
  .inv_kill      (inv_kill),
  .slot_dom_flat (slot_dom_flat),
  .slot_tag_flat (slot_tag_flat)
);

// File: tb/iotlb_dom_cache_bench.sv
`timescale 1ns/1ps
module iotlb_dom_cache_bench;
  localparam int NS = 8;
  localparam longint FALL = (64'd1 << 36) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, fill_passthru = 0, fill_first_en = 0, fill_scalable = 0;
  logic inv_valid = 0;
  logic [15:0] lk_sid = 0, fill_dom = 0, fill_sid = 0, inv_dom = 0;
  logic [19:0] lk_pasid = 0, fill_pasid = 0;
  logic [47:0] lk_addr = 0, fill_addr = 0, inv_addr = 0;
  logic [1:0]  fill_level = 0, fill_perm = 0, inv_kind = 0;
  logic [35:0] fill_hpfn = 0;
  logic [5:0]  inv_order = 0;
  logic        lk_resp_valid, lk_hit;
  logic [35:0] lk_frame;
  logic [1:0]  lk_perm;

  always #10 clk = ~clk;

  iotlb_dom_cache #(.NUM_SLOTS(NS)) u_iotlb_dom_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_sid(lk_sid), .lk_pasid(lk_pasid), .lk_addr(lk_addr),
    .lk_resp_valid(lk_resp_valid), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_passthru(fill_passthru), .fill_first_en(fill_first_en),
    .fill_scalable(fill_scalable), .fill_dom(fill_dom), .fill_sid(fill_sid),
    .fill_pasid(fill_pasid), .fill_addr(fill_addr), .fill_level(fill_level),
    .fill_hpfn(fill_hpfn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_dom(inv_dom),
    .inv_addr(inv_addr), .inv_order(inv_order)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference: parallel arrays indexed by slot number.
  bit     mv [NS];
  int     mdom [NS], msid [NS], mpas [NS], mperm [NS], mtag [NS];
  longint mgfn [NS], mpfm [NS], mhpfn [NS];
  int     rr = 0;
  bit     e_v = 0, e_hit = 0;
  longint e_frame = 0;
  int     e_perm = 0;

  function automatic longint pfm_of(int lvl);
    if (lvl == 2) return (FALL << 9) & FALL;
    if (lvl == 3) return (FALL << 18) & FALL;
    return FALL;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) mv[i] = 0;
      rr = 0;
      e_v <= 0; e_hit <= 0; e_frame <= 0; e_perm <= 0;
    end else begin
      bit found;
      longint ef, qf, rf, fm;
      int ep, vic;
      bit kill;
      found = 0; ef = 0; ep = 0;
      if (lk_valid) begin
        qf = longint'(lk_addr) >> 12;
        for (int i = 0; i < NS; i++)
          if (!found && mv[i] && msid[i] == int'(lk_sid) && mpas[i] == int'(lk_pasid) &&
              ((qf & mpfm[i]) == mgfn[i])) begin
            found = 1;
            ef = (mhpfn[i] & mpfm[i]) | (qf & ~mpfm[i] & FALL);
            ep = mperm[i];
          end
      end
      e_v <= lk_valid; e_hit <= found; e_frame <= ef; e_perm <= ep;
      if (inv_valid) begin
        rf = longint'(inv_addr) >> 12;
        fm = (FALL << inv_order) & FALL;
        for (int i = 0; i < NS; i++) if (mv[i]) begin
          kill = 0;
          case (inv_kind)
            2'b00: kill = 1;
            2'b01: kill = (mdom[i] == int'(inv_dom));
            2'b10: if (mdom[i] == int'(inv_dom)) begin
              if (mtag[i] == 1) kill = 1;
              else kill = ((mgfn[i] & fm) == (rf & fm)) || (mgfn[i] == (rf & mpfm[i]));
            end
            default: kill = 0;
          endcase
          if (kill) mv[i] = 0;
        end
      end
      if (fill_valid && !fill_passthru) begin
        vic = -1;
        for (int i = 0; i < NS; i++) if (vic < 0 && !mv[i]) vic = i;
        if (vic < 0) begin vic = rr; rr = (rr + 1) % NS; end
        mv[vic] = 1;
        mdom[vic] = int'(fill_dom); msid[vic] = int'(fill_sid); mpas[vic] = int'(fill_pasid);
        mpfm[vic] = pfm_of(int'(fill_level));
        mgfn[vic] = (longint'(fill_addr) >> 12) & mpfm[vic];
        mhpfn[vic] = longint'(fill_hpfn);
        mperm[vic] = int'(fill_perm);
        mtag[vic] = (fill_first_en && fill_scalable) ? 1 : 2;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done && (e_v || lk_resp_valid !== 1'b0)) begin
      n_tests++;
      if (lk_resp_valid !== e_v || lk_hit !== e_hit ||
          (e_hit && (lk_frame !== e_frame[35:0] || lk_perm !== e_perm[1:0]))) begin
        n_fail++;
        $display("FAIL %s: valid/hit/frame/perm actual %0d/%0d/%h/%0d expected %0d/%0d/%h/%0d",
                 cur_req, lk_resp_valid, lk_hit, lk_frame, lk_perm, e_v, e_hit, e_frame[35:0], e_perm);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0; fill_passthru = 0;
  endtask

  task automatic look(int sid, int pas, longint a);
    lk_valid = 1; lk_sid = sid[15:0]; lk_pasid = pas[19:0]; lk_addr = a[47:0];
    step();
  endtask

  task automatic fill_set(int dom, int sid, int pas, longint a, longint h, int lvl, int perm,
                          bit fs, bit sc, bit pt);
    fill_valid = 1; fill_dom = dom[15:0]; fill_sid = sid[15:0]; fill_pasid = pas[19:0];
    fill_addr = a[47:0]; fill_hpfn = h[35:0]; fill_level = lvl[1:0]; fill_perm = perm[1:0];
    fill_first_en = fs; fill_scalable = sc; fill_passthru = pt;
  endtask

  task automatic fill(int dom, int sid, int pas, longint a, longint h, int lvl, int perm,
                      bit fs, bit sc);
    fill_set(dom, sid, pas, a, h, lvl, perm, fs, sc, 0);
    step();
  endtask

  task automatic inv_set(int kind, int dom, longint a, int order);
    inv_valid = 1; inv_kind = kind[1:0]; inv_dom = dom[15:0]; inv_addr = a[47:0];
    inv_order = order[5:0];
  endtask

  task automatic inv(int kind, int dom, longint a, int order);
    inv_set(kind, dom, a, order);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_tests++;
    if (lk_resp_valid !== 0 || lk_hit !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: valid/hit actual %0d/%0d expected 0/0", lk_resp_valid, lk_hit);
    end
    cur_req = "R1 reset miss";
    look(1, 0, 48'h1000);
    step();

    cur_req = "R1 key match";
    fill(5, 1, 3, 48'h1234_5000, 36'hABCDE, 1, 3, 0, 0);
    look(1, 3, 48'h1234_5123);
    look(2, 3, 48'h1234_5000);
    look(1, 4, 48'h1234_5000);
    look(1, 3, 48'h1234_6000);

    cur_req = "R2 page sizes";
    fill(5, 1, 3, 48'h4020_0000, 36'h77000, 2, 1, 1, 1);
    look(1, 3, 48'h4025_3456);
    fill(6, 2, 0, 48'h80_4000_0000, 36'h300000, 3, 2, 0, 0);
    look(2, 0, 48'h80_4123_4000);

    cur_req = "R1 lowest slot wins";
    fill(5, 1, 3, 48'h1234_5000, 36'h11111, 1, 2, 0, 0);
    look(1, 3, 48'h1234_5000);
    fill(6, 2, 1, 48'h9000, 36'h22222, 1, 3, 1, 1);

    cur_req = "R7 R3 first-stage dropped, R6 other domain kept";
    inv(2, 5, 48'h7777_0000, 0);
    look(1, 3, 48'h4025_3456);
    look(1, 3, 48'h1234_5000);
    look(2, 1, 48'h9000);
    look(2, 0, 48'h80_4123_4000);

    cur_req = "R8 outside range kept, R7 first-stage dropped";
    inv(2, 6, 48'h1_0000, 0);
    look(2, 1, 48'h9000);
    look(2, 0, 48'h80_4123_4000);

    cur_req = "R8 narrow range inside large page";
    inv(2, 6, 48'h80_4000_3000, 0);
    look(2, 0, 48'h80_4123_4000);

    cur_req = "R8 wide range order";
    fill(5, 1, 3, 48'h1234_6000, 36'h33333, 1, 1, 0, 0);
    fill(5, 1, 3, 48'h1235_0000, 36'h44444, 1, 1, 0, 0);
    inv(2, 5, 48'h1234_0000, 4);
    look(1, 3, 48'h1234_5000);
    look(1, 3, 48'h1234_6000);
    look(1, 3, 48'h1235_0000);

    cur_req = "R3 first-stage without scalable is second-stage";
    fill(9, 4, 0, 48'h5000, 36'h55555, 1, 3, 1, 0);
    inv(2, 9, 48'hF000_0000, 0);
    look(4, 0, 48'h5000);

    cur_req = "R5 domain clear";
    fill(7, 5, 0, 48'hA000, 36'h1, 1, 1, 1, 1);
    fill(7, 5, 1, 48'hB000, 36'h2, 1, 1, 0, 0);
    fill(8, 5, 2, 48'hC000, 36'h3, 1, 1, 0, 0);
    inv(1, 7, 48'h0, 0);
    look(5, 0, 48'hA000);
    look(5, 1, 48'hB000);
    look(5, 2, 48'hC000);

    cur_req = "R9 reserved kind";
    inv(3, 8, 48'hC000, 0);
    look(5, 2, 48'hC000);

    cur_req = "R3 pass-through not installed";
    fill_set(8, 6, 0, 48'hD000, 36'h4, 1, 1, 0, 0, 1);
    step();
    look(6, 0, 48'hD000);

    cur_req = "R4 global clear";
    inv(0, 0, 48'h0, 0);
    look(5, 2, 48'hC000);
    look(1, 3, 48'h1235_0000);

    cur_req = "R10 fill order and round-robin";
    for (int i = 0; i < NS + 3; i++) fill(10, 3, i, longint'(i) << 12, 36'h100 + i, 1, 1, 0, 0);
    for (int i = 0; i < NS + 3; i++) look(3, i, longint'(i) << 12);

    cur_req = "R11 invalidate then fill same cycle";
    inv_set(0, 0, 48'h0, 0);
    fill_set(11, 7, 0, 48'hE000, 36'h999, 1, 2, 0, 0, 0);
    step();
    look(7, 0, 48'hE000);
    look(3, 5, 48'h5000);
    for (int i = 0; i < NS - 1; i++) fill(12, 8, i, 48'h20000, 36'h50 + i, 1, 1, 0, 0);
    inv_set(1, 12, 48'h0, 0);
    fill_set(12, 8, 99, 48'h21000, 36'h777, 1, 3, 0, 0, 0);
    step();
    look(8, 99, 48'h21000);
    look(8, 0, 48'h20000);
    look(7, 0, 48'hE000);
    step();
    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule